// File: doc/BRIEF.md
# Prescaled 8-bit Event Timer

This block counts time or external events in an 8-bit register that wraps around. Each count step is produced by a prescaler. The prescaler is fed from one of two sources. The internal source gives one tick on every second system clock. The external source gives one tick on each rising edge of an input pin, after that pin has been synchronized. A 4-bit divide code sets how many source ticks make one count step. Each time the count rolls over from its top value to zero, a sticky overflow flag is raised. Software clears the flag by writing a zero to it.

A stop input holds both the count and the partial prescale interval for as long as it is high. Any change of the divide code restarts the prescale interval from zero, so a new ratio never inherits a partly finished interval. The external pin goes through a synchronizer, and then through a two-state edge tracker. The tracker has the states `EDGE_LOW` and `EDGE_HIGH`. Its transition `EDGE_LOW -> EDGE_HIGH` happens when the synchronized level is 1 and emits one tick. Its transition `EDGE_HIGH -> EDGE_LOW` happens when the level is 0. Both states hold while the level stays the same. The tracker resets into `EDGE_LOW`.

Top module: `tick_timer8`

## Requirements
- R1: After reset, `count` is 0 and `ovf_flag` is 0.
- R2: With `src_ext`=0, the source ticks on the second clock edge after reset and on every second edge after that. With divide code 0, `count` therefore equals floor(N/2) after N edges.
- R3: With `src_ext`=1, each rising edge of `ext_pin` gives exactly one source tick. This holds when `ext_pin` stays high for at least two clocks and low for at least two clocks. The tick follows the pin through a two-flop synchronizer.
- R4: A divide code c in 0..8 gives one count step per 2^c source ticks. Codes 9..15 give one step per 256 ticks.
- R5: Each count step adds one to `count` modulo 256. A step taken from 0xFF sets `ovf_flag`.
- R6: While `stop` is 1, neither `count` nor the prescale interval advances. After `stop` is released, counting resumes from the same partial interval.
- R7: A write with `flag_wr`=1 and `flag_wdata`=0 clears `ovf_flag` on the next edge. A write of 1 has no effect. An overflow in the same cycle as a clearing write wins, and the flag stays set.
- R8: A change of `psc_code` discards the partial prescale interval. The first step at the new ratio then takes a full 2^c ticks, and the tick that arrives in the cycle of the change is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| src_ext | input | 1 | 1 selects the external pin as the source, 0 selects the system clock divided by 2 |
| ext_pin | input | 1 | External event input, asynchronous to clk |
| psc_code | input | 4 | Divide code |
| stop | input | 1 | Freezes counting while high |
| flag_wr | input | 1 | Write strobe for the overflow flag |
| flag_wdata | input | 1 | Data for the flag write; only 0 has an effect |
| count | output | 8 | Current count value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The edge tracker's one-tick-per-edge property assumes that `ext_pin` stays high for at least two clocks and low for at least two clocks, which keeps it below a quarter of the clock rate. The bench drives the pin in two-clock halves to stay inside this limit. The prescaler assertions assume that `psc_code` changes between clock edges. The bench drives every input at the falling edge, and it counts expected steps from the number of rising edges since reset was released.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_st_t;

endpackage

// File: rtl/tmr8_edge.sv
module tmr8_edge
    import tmr8_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    edge_st_t               state, state_nxt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EDGE_LOW;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        rise      = 1'b0;
        unique case (state)
            EDGE_LOW: begin
                if (lvl) begin
                    state_nxt = EDGE_HIGH;
                    rise      = 1'b1;
                end
            end
            EDGE_HIGH: begin
                if (!lvl) state_nxt = EDGE_LOW;
            end
        endcase
    end

    // R3: a tick marks an edge, so it cannot repeat on the next cycle
    p_single_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    p_state_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (state == EDGE_HIGH));

endmodule

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
    parameter int SEL_W = 4,
    parameter int PS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             stop,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    localparam logic [PS_W:0] ONE = {{PS_W{1'b0}}, 1'b1};

    logic [PS_W-1:0]  pscnt;
    logic [PS_W-1:0]  limit;
    logic [PS_W:0]    span;
    logic [SEL_W-1:0] sel_q;
    logic             sel_chg;
    logic             adv;

    always_comb begin
        span = (ONE << sel) - ONE;
        if (int'(sel) >= PS_W) limit = '1;
        else                   limit = span[PS_W-1:0];
    end

    assign sel_chg = (sel != sel_q);
    assign adv     = tick && !stop && !sel_chg;
    assign pulse   = adv && (pscnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pscnt <= '0;
            sel_q <= '0;
        end else begin
            sel_q <= sel;
            if (sel_chg)    pscnt <= '0;
            else if (pulse) pscnt <= '0;
            else if (adv)   pscnt <= pscnt + 1'b1;
        end
    end

    // R8: a new code starts the interval from zero
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (pscnt == '0));
    // R6: held while stopped
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !sel_chg) |=> $stable(pscnt));
    // R4: the partial interval never passes the selected ratio
    p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_chg |-> (pscnt <= limit));

endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clr_wr,
    input  logic             clr_data,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    logic wrap;
    logic clr_req;

    assign wrap    = step && (count == '1);
    assign clr_req = clr_wr && !clr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            flag  <= 1'b0;
        end else begin
            if (step)         count <= count + 1'b1;
            if (wrap)         flag  <= 1'b1;
            else if (clr_req) flag  <= 1'b0;
        end
    end

    p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count == $past(count) + 1'b1));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count == '1) |=> flag);
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !wrap) |=> !flag);
    p_flag_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);

endmodule

// File: rtl/tick_timer8.sv
module tick_timer8 #(
    parameter int CNT_W       = 8,
    parameter int SEL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_ext,
    input  logic             ext_pin,
    input  logic [SEL_W-1:0] psc_code,
    input  logic             stop,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);
    localparam int PS_W = CNT_W;

    logic half_q;
    logic ext_rise;
    logic src_tick;
    logic step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end

    tmr8_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .rise (ext_rise)
    );

    assign src_tick = src_ext ? ext_rise : half_q;

    tmr8_prescale #(.SEL_W(SEL_W), .PS_W(PS_W)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (src_tick),
        .stop (stop),
        .sel  (psc_code),
        .pulse(step)
    );

    tmr8_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .clr_wr  (flag_wr),
        .clr_data(flag_wdata),
        .count   (count),
        .flag    (ovf_flag)
    );

    // R2: the internal source never ticks on two edges in a row
    p_half_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ext && src_tick) |=> !half_q);
    // R6: a stopped timer does not move the count
    p_stop_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> $stable(count));

endmodule

// File: tb/tb_tick_timer8.sv
module tb_tick_timer8;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       src_ext, ext_pin, stop, flag_wr, flag_wdata;
    logic [3:0] psc_code;
    logic [7:0] count;
    logic       ovf_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tick_timer8 dut (
        .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .ext_pin(ext_pin),
        .psc_code(psc_code), .stop(stop), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .count(count), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic ext, input logic [3:0] code);
        @(negedge clk);
        rst_n = 1'b0; src_ext = ext; psc_code = code; stop = 1'b0;
        flag_wr = 1'b0; flag_wdata = 1'b1; ext_pin = 1'b0;
        run(3);
        rst_n = 1'b1;
    endtask

    function automatic int ratio(input int c);
        return (c > 8) ? 256 : (1 << c);
    endfunction

    task automatic pin_pulses(input int k);
        for (int i = 0; i < k; i++) begin
            ext_pin = 1'b1; run(2);
            ext_pin = 1'b0; run(2);
        end
        run(4);
    endtask

    initial begin
        rst_n = 1'b0; src_ext = 1'b0; ext_pin = 1'b0; psc_code = '0;
        stop = 1'b0; flag_wr = 1'b0; flag_wdata = 1'b1;

        // R1 reset state
        do_reset(1'b0, 4'd0);
        check("R1 count", count, 0);
        check("R1 flag", ovf_flag, 0);

        // R2 internal half rate, code 0
        run(7);
        check("R2 count after 7 edges", count, 3);
        run(1);
        check("R2 count after 8 edges", count, 4);

        // R4 sweep of every divide code
        for (int c = 0; c < 16; c++) begin
            do_reset(1'b0, 4'(c));
            run(2 * ratio(c) * 3 - 1);
            check($sformatf("R4 code %0d before step", c), count, 2);
            run(1);
            check($sformatf("R4 code %0d at step", c), count, 3);
        end

        // R5 wrap and flag; R7 set beats clear, then clear
        do_reset(1'b0, 4'd0);
        run(511);
        check("R5 count before wrap", count, 255);
        check("R5 flag before wrap", ovf_flag, 0);
        flag_wr = 1'b1; flag_wdata = 1'b0;
        run(1);
        check("R5 count wrapped", count, 0);
        check("R7 overflow wins over clear", ovf_flag, 1);
        run(1);
        check("R7 clear by writing 0", ovf_flag, 0);
        flag_wdata = 1'b1;
        run(1);
        check("R7 write 1 leaves clear flag", ovf_flag, 0);
        flag_wr = 1'b0;
        run(1024 - 514);
        check("R5 second wrap sets flag", ovf_flag, 1);
        flag_wr = 1'b1; flag_wdata = 1'b1;
        run(3);
        check("R7 write 1 leaves set flag", ovf_flag, 1);
        flag_wr = 1'b0;

        // R6 stop freezes count and partial interval (code 2)
        do_reset(1'b0, 4'd2);
        run(12);
        check("R6 count before stop", count, 1);
        stop = 1'b1;
        run(40);
        check("R6 count held while stopped", count, 1);
        stop = 1'b0;
        run(3);
        check("R6 partial interval kept", count, 1);
        run(1);
        check("R6 step after resume", count, 2);

        // R8 code change restarts interval
        do_reset(1'b0, 4'd3);
        run(14);
        check("R8 no step before change", count, 0);
        psc_code = 4'd2;
        run(7);
        check("R8 old partial interval discarded", count, 0);
        run(1);
        check("R8 full new interval", count, 1);

        // R3 external source
        do_reset(1'b1, 4'd0);
        run(2);
        pin_pulses(3);
        check("R3 three edges code 0", count, 3);
        pin_pulses(7);
        check("R3 ten edges code 0", count, 10);
        run(20);
        check("R3 idle pin adds nothing", count, 10);
        psc_code = 4'd2;
        run(2);
        pin_pulses(9);
        check("R3 nine edges code 2", count, 12);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule